// File: doc/BRIEF.md
# Dual-Clock Read Buffer with Split-Bank Mode

This block moves corrected memory words from the memory clock domain into the system clock domain. Words enter on the memory clock under an active-low write enable and leave on the system clock under an active-low read enable. The storage works as a single 16-entry queue or as two independent 8-entry queues. In the dual setting, a bank input on each side picks the half that side addresses. Three active-low status flags report empty, at-or-above-half and full for the currently addressed half.

A path-select input routes traffic. When it is high, incoming words go into the queue and the output shows the last word popped from it. When it is low, incoming words are held in a single bypass register, the queue is left alone, and the output shows that register. Read and write positions cross between the clocks as Gray code through two-stage synchronizers. As a result, every flag errs on the safe side and settles once the far clock has run a few edges.

The enables are plain strobes with no ready signal. Back-pressure is the user's job: a writer must watch `full_n` and a reader must watch `empty_n`. A strobe that runs into a full or empty queue is dropped without any side effect.

Top module: `xclk_rdbuf`

## Requirements
- R1: On a rising `mclk` edge with `wr_en_n` low, `path_sel` high and the addressed half not full, `wr_data` is appended to that half.
- R2: On a rising `sclk` edge with `rd_en_n` low and the addressed half not empty, the oldest word of that half is removed and appears on `rd_data` (with `path_sel` high) after that edge. Otherwise the value shown stays as it was.
- R3: `empty_n` is low while the half chosen by `rd_bank` holds no word. Reset drives `empty_n` low, `full_n` high, `half_n` high and `rd_data` to zero.
- R4: `full_n` is low while the half chosen by `wr_bank` holds its capacity: 16 in single mode, 8 per half in split mode.
- R5: `half_n` is low while the half chosen by `wr_bank` holds at least 8 words (single mode) or at least 4 words (split mode), and high below that.
- R6: A write strobe into a full half and a read strobe from an empty half are ignored. Stored words, their order and `rd_data` do not change.
- R7: Positions cross domains as Gray code through two flops each. A flag never reports space or data that does not yet exist: `full_n` stays low and `empty_n` stays low until the far side's update has been synchronized. Flags are exact after four edges of each clock without traffic.
- R8: `split_mode` = 1 selects two 8-entry halves; `wr_bank`/`rd_bank` pick the half (0 lower, 1 upper), and each half keeps its own order. With `split_mode` = 0 the bank inputs have no effect.
- R9: With `path_sel` low, a write strobe loads `wr_data` into the bypass register only, and `rd_data` shows that register. With `path_sel` high, `rd_data` shows the last word popped.
- R10: `rst_n` (active low, asynchronous) clears all positions in both domains together. `split_mode` is sampled only as a static setting and may change only while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Memory-side clock (write side) |
| sclk | input | 1 | System-side clock (read side) |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| split_mode | input | 1 | 0: one 16-entry queue, 1: two 8-entry halves |
| wr_bank | input | 1 | Half addressed by writes in split mode |
| wr_en_n | input | 1 | Active-low write strobe (memory clock) |
| wr_data | input | DW | Word to store |
| rd_bank | input | 1 | Half addressed by reads in split mode |
| rd_en_n | input | 1 | Active-low read strobe (system clock) |
| path_sel | input | 1 | 1: queue path, 0: bypass register path |
| rd_data | output | DW | Output word (queue or bypass) |
| empty_n | output | 1 | Low when the read-addressed half is empty |
| half_n | output | 1 | Low at or above the half-level threshold |
| full_n | output | 1 | Low when the write-addressed half is full |

## Verification
The queue is exercised with full sweeps in each mode: fill to capacity, overrun by one, drain, and under-run by one. These sweeps separate correct order from lost or duplicated words and pin the half-level threshold to 8 or 4. A snapshot taken one nanosecond after the local edge, before the far clock can respond, tells a safe flag from an optimistic one. Random write/read mixes with random bank choice in split mode show whether the two halves stay independent. Random bypass writes show whether the bypass register disturbs the stored queue or the popped word.

// File: rtl/rbuf_pkg.sv
`timescale 1ns/1ps
package rbuf_pkg;
  localparam int RB_NBANK = 2;

  typedef enum logic {
    RB_SINGLE = 1'b0,
    RB_SPLIT  = 1'b1
  } rb_mode_e;
endpackage

// File: rtl/rbuf_sync.sv
`timescale 1ns/1ps
module rbuf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rbuf_ptr.sv
`timescale 1ns/1ps
// One side's position logic for both halves. IS_WR picks whether the
// level counts toward full (write side) or toward empty (read side).
module rbuf_ptr #(
  parameter int DEPTH = 16,
  parameter bit IS_WR = 1'b1,
  localparam int NB = rbuf_pkg::RB_NBANK,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   split,
  input  logic                   bank,
  input  logic                   req,
  input  logic [NB-1:0][PW-1:0]  oth_gray,
  output logic [NB-1:0][PW-1:0]  own_gray,
  output logic [AW-1:0]          addr,
  output logic                   fire,
  output logic [PW-1:0]          level
);
  logic [NB-1:0][PW-1:0] bin_q;
  logic [NB-1:0][PW-1:0] oth_bin;
  logic [NB-1:0][PW-1:0] lvl;
  logic [PW-1:0]         cap;
  logic [PW-1:0]         nxt;
  logic                  sel;
  logic                  blocked;

  assign cap = split ? PW'(DEPTH / 2) : PW'(DEPTH);
  assign sel = split & bank;

  // Gray to binary for the far side, then per-half fill level.
  // Split mode counts modulo DEPTH, so the top bit is dropped.
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < PW; i++) begin
        oth_bin[b][i] = ^(oth_gray[b] >> i);
      end
      lvl[b] = IS_WR ? (bin_q[b] - oth_bin[b]) : (oth_bin[b] - bin_q[b]);
      if (split) lvl[b][PW-1] = 1'b0;
    end
  end

  assign level   = lvl[sel];
  assign blocked = IS_WR ? (level == cap) : (level == '0);
  assign fire    = req & ~blocked;

  always_comb begin
    nxt = bin_q[sel] + 1'b1;
    if (split) nxt[PW-1] = 1'b0;
  end

  always_comb begin
    addr = bin_q[sel][AW-1:0];
    if (split) addr[AW-1] = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q    <= '0;
      own_gray <= '0;
    end else if (fire) begin
      bin_q[sel]    <= nxt;
      own_gray[sel] <= nxt ^ (nxt >> 1);
    end
  end

  // R6: a strobe that meets a full/empty half leaves positions untouched
  p_hold_when_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && blocked) |=> $stable(bin_q));

  // R4: the visible level never exceeds the capacity of the mode
  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= cap);

  for (genvar b = 0; b < NB; b++) begin : g_gray_chk
    // R7: the value crossing domains changes in at most one bit per edge
    p_gray_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(own_gray[b] ^ $past(own_gray[b])) <= 1);
  end
endmodule

// File: rtl/rbuf_mem.sv
`timescale 1ns/1ps
module rbuf_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  rq <= '0;
    else if (re) rq <= cells[raddr];
  end
endmodule

// File: rtl/xclk_rdbuf.sv
`timescale 1ns/1ps
module xclk_rdbuf
  import rbuf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          mclk,
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          split_mode,
  input  logic          wr_bank,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_bank,
  input  logic          rd_en_n,
  input  logic          path_sel,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          half_n,
  output logic          full_n
);
  localparam int NB = RB_NBANK;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  rb_mode_e              mode;
  logic                  split;
  logic [NB-1:0][PW-1:0] wg, rg, wg_s, rg_s;
  logic [AW-1:0]         waddr, raddr;
  logic                  wfire, rfire;
  logic [PW-1:0]         wlvl, rlvl, wcap;
  logic [DW-1:0]         fifo_q, byp_q;

  assign mode  = split_mode ? RB_SPLIT : RB_SINGLE;
  assign split = (mode == RB_SPLIT);
  assign wcap  = split ? PW'(DEPTH / 2) : PW'(DEPTH);

  rbuf_ptr #(.DEPTH(DEPTH), .IS_WR(1'b1)) u_wptr (
    .clk(mclk), .rst_n(rst_n), .split(split), .bank(wr_bank),
    .req(~wr_en_n & path_sel), .oth_gray(rg_s), .own_gray(wg),
    .addr(waddr), .fire(wfire), .level(wlvl));

  rbuf_ptr #(.DEPTH(DEPTH), .IS_WR(1'b0)) u_rptr (
    .clk(sclk), .rst_n(rst_n), .split(split), .bank(rd_bank),
    .req(~rd_en_n), .oth_gray(wg_s), .own_gray(rg),
    .addr(raddr), .fire(rfire), .level(rlvl));

  rbuf_sync #(.W(NB * PW)) u_w2r (.clk(sclk), .rst_n(rst_n), .d(wg), .q(wg_s));
  rbuf_sync #(.W(NB * PW)) u_r2w (.clk(mclk), .rst_n(rst_n), .d(rg), .q(rg_s));

  rbuf_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .wclk(mclk), .we(wfire), .waddr(waddr), .wdata(wr_data),
    .rclk(sclk), .rst_n(rst_n), .re(rfire), .raddr(raddr), .rq(fifo_q));

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n)                     byp_q <= '0;
    else if (!wr_en_n && !path_sel) byp_q <= wr_data;
  end

  assign rd_data = path_sel ? fifo_q : byp_q;
  assign empty_n = (rlvl != '0);
  assign full_n  = (wlvl != wcap);
  assign half_n  = (wlvl < (wcap >> 1));

  // R9: a bypass write never advances the queue's write position
  p_bypass_keeps_fifo_r9: assert property (@(posedge mclk) disable iff (!rst_n)
    (!wr_en_n && !path_sel) |=> $stable(wg));

  // R2: without a read strobe the popped word is held
  p_pop_hold_r2: assert property (@(posedge sclk) disable iff (!rst_n)
    rd_en_n |=> $stable(fifo_q));
endmodule

// File: tb/xclk_rdbuf_tb.sv
`timescale 1ns/1ps
module xclk_rdbuf_tb;
  localparam int DW    = 16;
  localparam int DEPTH = 16;

  logic mclk = 1'b0, sclk = 1'b0, rst_n = 1'b0;
  logic split_mode = 1'b0, wr_bank = 1'b0, rd_bank = 1'b0;
  logic wr_en_n = 1'b1, rd_en_n = 1'b1, path_sel = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic empty_n, half_n, full_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] mq0[$], mq1[$];
  logic [DW-1:0] last_q = '0, byp_q = '0;

  always #4 sclk = ~sclk;    // 125 MHz system clock
  always #5.5 mclk = ~mclk;  // memory clock

  xclk_rdbuf #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .mclk(mclk), .sclk(sclk), .rst_n(rst_n), .split_mode(split_mode),
    .wr_bank(wr_bank), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .rd_bank(rd_bank), .rd_en_n(rd_en_n), .path_sel(path_sel),
    .rd_data(rd_data), .empty_n(empty_n), .half_n(half_n), .full_n(full_n));

  function automatic int cap_f();
    return split_mode ? DEPTH / 2 : DEPTH;
  endfunction

  function automatic int qsize(input logic b);
    if (split_mode && b) return mq1.size();
    return mq0.size();
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge mclk);
    repeat (4) @(posedge sclk);
    #1;
  endtask

  task automatic check_flags();
    chk("R3 empty flag", 32'(empty_n), 32'(qsize(rd_bank) != 0));
    chk("R4 full flag",  32'(full_n),  32'(qsize(wr_bank) != cap_f()));
    chk("R5 half flag",  32'(half_n),  32'(qsize(wr_bank) < cap_f() / 2));
  endtask

  // R1 / R9: one write strobe on the memory clock
  task automatic do_wr(input logic b, input logic [DW-1:0] d, input logic ps);
    bit was_empty;
    was_empty = (qsize(rd_bank) == 0) && (!split_mode || rd_bank == b);
    @(negedge mclk);
    wr_bank = b; wr_data = d; path_sel = ps; wr_en_n = 1'b0;
    @(posedge mclk);
    #1 wr_en_n = 1'b1;
    if (!ps) byp_q = d;
    else if (qsize(b) < cap_f()) begin
      if (split_mode && b) mq1.push_back(d);
      else mq0.push_back(d);
    end
    chk("R1 full flag right after write", 32'(full_n), 32'(qsize(b) != cap_f()));
    if (ps && was_empty)
      chk("R7 empty stays low before sync", 32'(empty_n), 32'(0));
    settle();
    chk("R9 output select", 32'(rd_data), 32'(ps ? last_q : byp_q));
    check_flags();
  endtask

  // R2 / R6: one read strobe on the system clock
  task automatic do_rd(input logic b);
    bit was_full;
    was_full = (qsize(wr_bank) == cap_f()) && (!split_mode || wr_bank == b);
    @(negedge sclk);
    rd_bank = b; path_sel = 1'b1; rd_en_n = 1'b0;
    @(posedge sclk);
    #1 rd_en_n = 1'b1;
    if (qsize(b) > 0) begin
      if (split_mode && b) last_q = mq1.pop_front();
      else last_q = mq0.pop_front();
    end
    if (was_full)
      chk("R7 full stays low before sync", 32'(full_n), 32'(0));
    settle();
    chk("R2 read data", 32'(rd_data), 32'(last_q));
    check_flags();
  endtask

  // R10: mode is set only while reset is held
  task automatic do_reset(input logic sm);
    rst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1; path_sel = 1'b1;
    wr_bank = 1'b0; rd_bank = 1'b0; split_mode = sm;
    mq0.delete(); mq1.delete(); last_q = '0; byp_q = '0;
    repeat (3) @(negedge sclk);
    rst_n = 1'b1;
    settle();
    chk("R3 reset empty_n", 32'(empty_n), 32'(0));
    chk("R3 reset full_n",  32'(full_n),  32'(1));
    chk("R3 reset half_n",  32'(half_n),  32'(1));
    chk("R10 reset data",   32'(rd_data), 32'(0));
  endtask

  task automatic random_ops(input int n);
    for (int k = 0; k < n; k++) begin
      logic b;
      b = 1'($urandom % 2);
      if ($urandom % 100 < 52)
        do_wr(b, DW'($urandom), 1'($urandom % 8 != 0));
      else
        do_rd(b);
    end
  endtask

  initial begin
    void'($urandom(32'd917));
    do_reset(1'b0);

    // Single mode: random bank inputs must have no effect (R8)
    for (int i = 0; i < DEPTH; i++) do_wr(1'($urandom % 2), DW'(16'h1000 + i), 1'b1);
    do_wr(1'b1, 16'hdead, 1'b1);                 // R6 overrun dropped
    for (int i = 0; i < DEPTH; i++) do_rd(1'($urandom % 2));
    chk("R8 single mode order end", 32'(last_q), 32'(16'h100f));
    do_rd(1'b0);                                 // R6 under-run dropped
    chk("R6 under-run keeps data", 32'(rd_data), 32'(16'h100f));
    do_wr(1'b0, 16'hbeef, 1'b0);                 // R9 bypass path
    chk("R9 bypass leaves queue empty", 32'(empty_n), 32'(0));
    do_rd(1'b0);
    random_ops(150);

    // Split mode: independent halves
    do_reset(1'b1);
    for (int i = 0; i < DEPTH / 2; i++) do_wr(1'b0, DW'(16'h2000 + i), 1'b1);
    do_wr(1'b0, 16'haaaa, 1'b1);                 // R6 overrun of lower half
    do_wr(1'b1, 16'h3000, 1'b1);
    chk("R8 upper half not full", 32'(full_n), 32'(1));
    do_rd(1'b1);
    chk("R8 upper half first word", 32'(rd_data), 32'(16'h3000));
    do_rd(1'b0);
    chk("R8 lower half first word", 32'(rd_data), 32'(16'h2000));
    random_ops(300);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule